// File: doc/BRIEF.md
# Frequency-Change Watchdog Recovery Controller

This block guards the frequency selection of a programmable clock generator. A host programs it through a small register interface with two addresses. One address holds the control and status bits. The other holds the frequency select code that drives the clock synthesizer.

When the host changes the frequency select, the block can emit an active-low system reset pulse. It can also start a countdown watchdog that runs on a tick-enable input. If the watchdog is not stopped before it expires, the block does four things:
- it forces the frequency select to a fixed recovery code;
- it enters recovery mode and refuses further frequency writes;
- it sets a sticky timeout flag;
- it can fire the reset pulse.

The host leaves recovery mode by writing 0 to the watchdog enable.

All pins are plain control and status pins. Writes are single-cycle strobes that are always accepted, and there is no back-pressure. The control register is always visible on `ctrl_rdata`.

Top module: `fcw_recovery_ctrl`

## Requirements
- R1: After reset, `ctrl_rdata` is 0, `freq_sel` equals `FSEL_RST`, `recovery` is 0 and `sys_rst_n` is 1.
- R2: A write to address 0 sets the control bits. Bit 0 is the watchdog enable, bit 2 is the reset-on-change enable and bit 3 is the reset-on-timeout enable. All three read back at the same positions on `ctrl_rdata`, and bit 1 reads the timeout flag.
- R3: A write to address 1 is a frequency change only if its low `FSEL_W` bits differ from `freq_sel` and the block is not in recovery mode. A change shows on `freq_sel` one cycle after the write. A write of the current value is not a change.
- R4: The watchdog starts only on a frequency change made while the enable is 1. Setting the enable alone, or making a change while the enable is 0, never leads to a timeout.
- R5: The `WD_RELOAD`-th tick after the arming write causes a timeout. From the next cycle, `freq_sel` equals `REC_FSEL`, `recovery` is 1 and the timeout flag reads 1.
- R6: In recovery mode, frequency writes are ignored and `freq_sel` stays at `REC_FSEL`.
- R7: Writing 0 to the enable stops and reloads the timer and clears `recovery`. Setting the enable again does not restart the count until the next frequency change.
- R8: On address 0, writing 1 to bit 1 clears the timeout flag and writing 0 leaves it unchanged.
- R9: With reset-on-change enabled, each accepted change drives `sys_rst_n` low from the next cycle for `RST_PULSE_LEN` cycles.
- R10: With reset-on-timeout enabled, a timeout drives `sys_rst_n` low from the next cycle for `RST_PULSE_LEN` cycles.
- R11: A trigger that arrives while the pulse is active keeps `sys_rst_n` low without a gap until `RST_PULSE_LEN` cycles after that latest trigger.
- R12: A frequency change while the watchdog runs restarts the countdown from `WD_RELOAD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Watchdog count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = frequency select |
| wr_data | input | 8 | Write data |
| ctrl_rdata | output | 8 | Control/status register contents |
| freq_sel | output | FSEL_W | Current frequency select |
| recovery | output | 1 | Recovery mode flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The bench covers these corner cases, and what a wrong design would do in each:
- Rewriting the current frequency: a design that treats it as a change would fire a pulse.
- Enabling the watchdog without a frequency change: a design that starts counting on the enable alone would time out.
- A second change late in the countdown: a design that does not reload would time out early.
- Write-0 and write-1 to the status bit: a wrong design would lose the flag, or never clear it.
- Frequency writes in recovery mode: a wrong design would let them slip through.
- Re-enabling after unlock: a wrong design would restart the timer with no change.
- A second trigger inside an active pulse: a wrong design would release reset early or put a high glitch in it.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_FSEL = 1'b1;
  localparam int CB_WDEN  = 0;
  localparam int CB_TOSTS = 1;
  localparam int CB_RSTFC = 2;
  localparam int CB_RSTTO = 3;
endpackage

// File: rtl/fcw_wdt_timer.sv
module fcw_wdt_timer #(
  parameter int RELOAD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic halt,
  output logic expire
);
  localparam int CW = $clog2(RELOAD + 1);
  localparam logic [CW-1:0] LOAD = CW'(RELOAD);

  logic          running;
  logic [CW-1:0] cnt;

  assign expire = running && tick && (cnt == CW'(1)) && !halt && !arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= LOAD;
    end else if (halt) begin
      running <= 1'b0;
      cnt     <= LOAD;
    end else if (arm) begin
      running <= 1'b1;
      cnt     <= LOAD;
    end else if (expire) begin
      running <= 1'b0;
      cnt     <= LOAD;
    end else if (running && tick) begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/fcw_rst_pulse.sv
module fcw_rst_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse_n
);
  localparam int PW = $clog2(LEN + 1);

  logic [PW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (trig)            remain <= PW'(LEN);
    else if (remain != '0)    remain <= remain - PW'(1);
  end

  assign pulse_n = (remain == '0);
endmodule

// File: rtl/fcw_ctrl_regs.sv
module fcw_ctrl_regs
  import fcw_pkg::*;
#(
  parameter int                FSEL_W   = 4,
  parameter logic [FSEL_W-1:0] FSEL_RST = '0,
  parameter logic [FSEL_W-1:0] REC_FSEL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              expire,
  output logic              wd_en,
  output logic              to_sts,
  output logic              rst_fc_en,
  output logic              rst_to_en,
  output logic [FSEL_W-1:0] freq,
  output logic              rec,
  output logic              fchg,
  output logic              halt
);
  logic ctrl_wr, fs_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign fs_wr   = wr_en && (wr_addr == ADDR_FSEL);
  assign halt    = ctrl_wr && !wr_data[CB_WDEN];
  assign fchg    = fs_wr && !rec && (wr_data[FSEL_W-1:0] != freq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_en     <= 1'b0;
      to_sts    <= 1'b0;
      rst_fc_en <= 1'b0;
      rst_to_en <= 1'b0;
      freq      <= FSEL_RST;
      rec       <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        wd_en     <= wr_data[CB_WDEN];
        rst_fc_en <= wr_data[CB_RSTFC];
        rst_to_en <= wr_data[CB_RSTTO];
      end
      if (expire)                             to_sts <= 1'b1;
      else if (ctrl_wr && wr_data[CB_TOSTS])  to_sts <= 1'b0;
      if (halt)        rec <= 1'b0;
      else if (expire) rec <= 1'b1;
      if (expire)      freq <= REC_FSEL;
      else if (fchg)   freq <= wr_data[FSEL_W-1:0];
    end
  end
endmodule

// File: rtl/fcw_recovery_ctrl.sv
module fcw_recovery_ctrl
  import fcw_pkg::*;
#(
  parameter int                FSEL_W        = 4,
  parameter logic [FSEL_W-1:0] FSEL_RST      = '0,
  parameter logic [FSEL_W-1:0] REC_FSEL      = FSEL_W'(10),
  parameter int                WD_RELOAD     = 1024,
  parameter int                RST_PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        ctrl_rdata,
  output logic [FSEL_W-1:0] freq_sel,
  output logic              recovery,
  output logic              sys_rst_n
);
  logic wd_en, to_sts, rst_fc_en, rst_to_en;
  logic fchg, halt, arm, expire, trig;

  fcw_ctrl_regs #(
    .FSEL_W(FSEL_W), .FSEL_RST(FSEL_RST), .REC_FSEL(REC_FSEL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .expire(expire), .wd_en(wd_en), .to_sts(to_sts),
    .rst_fc_en(rst_fc_en), .rst_to_en(rst_to_en), .freq(freq_sel),
    .rec(recovery), .fchg(fchg), .halt(halt)
  );

  assign arm = fchg && wd_en;

  fcw_wdt_timer #(.RELOAD(WD_RELOAD)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .halt(halt),
    .expire(expire)
  );

  assign trig = (fchg && rst_fc_en) || (expire && rst_to_en);

  fcw_rst_pulse #(.LEN(RST_PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(trig), .pulse_n(sys_rst_n)
  );

  always_comb begin
    ctrl_rdata           = '0;
    ctrl_rdata[CB_WDEN]  = wd_en;
    ctrl_rdata[CB_TOSTS] = to_sts;
    ctrl_rdata[CB_RSTFC] = rst_fc_en;
    ctrl_rdata[CB_RSTTO] = rst_to_en;
  end
endmodule

// File: rtl/fcw_recovery_chk.sv
module fcw_recovery_chk #(
  parameter int                FSEL_W   = 4,
  parameter logic [FSEL_W-1:0] REC_FSEL = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        ctrl_rdata,
  input logic [FSEL_W-1:0] freq_sel,
  input logic              recovery,
  input logic              sys_rst_n,
  input logic              expire,
  input logic              trig
);
  assert_rec_freq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    recovery |-> freq_sel == REC_FSEL);

  assert_rec_ignores_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (recovery && wr_en && wr_addr) |=> $stable(freq_sel));

  assert_rec_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovery) |-> ctrl_rdata[1]);

  assert_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && !wr_data[0]) |=> !recovery);

  assert_flag_write0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && !wr_data[1] && ctrl_rdata[1]) |=> ctrl_rdata[1]);

  assert_same_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && wr_data[FSEL_W-1:0] == freq_sel && !expire) |=> $stable(freq_sel));

  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_n) |-> $past(trig));
endmodule

bind fcw_recovery_ctrl fcw_recovery_chk #(.FSEL_W(FSEL_W), .REC_FSEL(REC_FSEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctrl_rdata(ctrl_rdata), .freq_sel(freq_sel), .recovery(recovery),
  .sys_rst_n(sys_rst_n), .expire(expire), .trig(trig)
);

// File: tb/fcw_recovery_ctrl_bench.sv
module fcw_recovery_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW  = 4;
  localparam int RL  = 24;
  localparam int PL  = 5;
  localparam logic [FW-1:0] REC = 4'hA;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl_rdata;
  logic [FW-1:0] freq_sel;
  logic recovery, sys_rst_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcw_recovery_ctrl #(.FSEL_W(FW), .FSEL_RST(4'h0), .REC_FSEL(REC),
                      .WD_RELOAD(RL), .RST_PULSE_LEN(PL)) u_fcw_recovery_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_rdata(ctrl_rdata), .freq_sel(freq_sel),
    .recovery(recovery), .sys_rst_n(sys_rst_n));

  // behavioural reference model
  int m_wden, m_sts, m_fc, m_to, m_freq, m_rec, m_run, m_cnt, m_pc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wden = 0; m_sts = 0; m_fc = 0; m_to = 0; m_freq = 0; m_rec = 0;
      m_run = 0; m_cnt = RL; m_pc = 0;
    end else begin
      int halt, chg, arm, ex, trg;
      halt = (wr_en && !wr_addr && !wr_data[0]);
      chg  = (wr_en && wr_addr && !m_rec && (int'(wr_data[3:0]) != m_freq));
      arm  = chg && m_wden;
      ex   = m_run && tick && m_cnt == 1 && !halt && !arm;
      trg  = (chg && m_fc) || (ex && m_to);
      if (halt) begin m_run = 0; m_cnt = RL; end
      else if (arm) begin m_run = 1; m_cnt = RL; end
      else if (ex) begin m_run = 0; m_cnt = RL; end
      else if (m_run && tick) m_cnt = m_cnt - 1;
      if (trg) m_pc = PL; else if (m_pc > 0) m_pc = m_pc - 1;
      if (ex) m_sts = 1; else if (wr_en && !wr_addr && wr_data[1]) m_sts = 0;
      if (halt) m_rec = 0; else if (ex) m_rec = 1;
      if (ex) m_freq = int'(REC); else if (chg) m_freq = int'(wr_data[3:0]);
      if (wr_en && !wr_addr) begin
        m_wden = wr_data[0]; m_fc = wr_data[2]; m_to = wr_data[3];
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 freq_sel model", int'(freq_sel), m_freq);
    chk("R6 recovery model", int'(recovery), m_rec);
    chk("R8 ctrl_rdata model", int'(ctrl_rdata),
        m_wden | (m_sts << 1) | (m_fc << 2) | (m_to << 3));
    chk("R9 sys_rst_n model", int'(sys_rst_n), m_pc == 0 ? 1 : 0);
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", int'(ctrl_rdata), 0);
    chk("R1 freq", int'(freq_sel), 0);
    chk("R1 recovery", int'(recovery), 0);
    chk("R1 sys_rst_n", int'(sys_rst_n), 1);
    rst_n = 1;
    step();
    wr(0, 8'h0D);
    chk("R2 ctrl readback", int'(ctrl_rdata), 8'h0D);
    wr(1, 8'h00);
    chk("R3 same value no pulse", int'(sys_rst_n), 1);
    for (int i = 0; i < RL*3; i++) begin tick = 1'($urandom % 2); step(); end
    chk("R4 enable alone no timeout", int'(recovery), 0);
    tick = 1;
    wr(1, 8'h05);
    chk("R3 change applied", int'(freq_sel), 5);
    chk("R9 pulse low", int'(sys_rst_n), 0);
    repeat (PL-1) step();
    chk("R9 pulse still low", int'(sys_rst_n), 0);
    step();
    chk("R9 pulse ends", int'(sys_rst_n), 1);
    repeat (RL-PL-3) step();
    wr(1, 8'h06);
    repeat (RL-1) step();
    chk("R12 restart no early timeout", int'(recovery), 0);
    step();
    chk("R5 recovery", int'(recovery), 1);
    chk("R5 freq", int'(freq_sel), int'(REC));
    chk("R5 flag", int'(ctrl_rdata), 8'h0F);
    chk("R10 timeout pulse", int'(sys_rst_n), 0);
    wr(1, 8'h09);
    chk("R6 write ignored", int'(freq_sel), int'(REC));
    wr(0, 8'h0D);
    chk("R8 write0 keeps flag", int'(ctrl_rdata[1]), 1);
    wr(0, 8'h0F);
    chk("R8 write1 clears flag", int'(ctrl_rdata), 8'h0D);
    chk("R8 lock kept", int'(recovery), 1);
    wr(0, 8'h0C);
    chk("R7 unlock", int'(recovery), 0);
    chk("R7 rdata", int'(ctrl_rdata), 8'h0C);
    wr(0, 8'h0D);
    repeat (RL+2) step();
    chk("R7 no restart on enable", int'(recovery), 0);
    wr(1, 8'h03);
    chk("R7 writes accepted", int'(freq_sel), 3);
    step(); step();
    wr(1, 8'h04);
    repeat (PL-1) step();
    chk("R11 extended low", int'(sys_rst_n), 0);
    step();
    chk("R11 release", int'(sys_rst_n), 1);
    wr(0, 8'h00);
    wr(1, 8'h07);
    repeat (RL+3) step();
    chk("R4 disabled change no timeout", int'(recovery), 0);
    chk("R4 freq", int'(freq_sel), 7);
    finish_run();
  end
endmodule